// File: doc/BRIEF.md
# SPI Serial-Memory Command Controller

This block lets software talk to an external SPI flash through a small 32-bit register file. There are five registers: a mode register, a command register, a status register, a transmit data word and a receive data word. All SPI traffic uses mode 3. The clock idles high, the controller drives data while the clock is low, and both sides sample on the rising edge. The SPI clock runs at half the system clock.

In software mode, a single write to the command register starts a whole transaction. The controller asserts one of four chip selects and shifts out between one and four bytes from the transmit word. It then clocks in up to three bytes, and only after that releases the chip select. Two command-register bits are shortcuts that make the controller produce a flash opcode by itself. One reads the flash status byte and returns it in the status register. The other sends write-enable. A sticky completion flag in the status register tells software that the transaction has ended. Software clears the flag by writing zero to its bit.

Top module: `spi_mem_ctrl`

## Requirements
- R1: After reset all chip selects are high (inactive), `sclk` is high, and every register reads zero.
- R2: Mode 3 timing. `sclk` is high whenever no chip select is active. While a chip select is active, `mosi` changes only while `sclk` is low. Each bit period is two system clocks.
- R3: The mode register is at offset 0x00 and its bit 28 selects software mode. The command register is at 0x04. Writing it with bit 7 set starts a transfer, but only when software mode is selected. The transfer sends N bytes of the transmit word (offset 0x0C), where N is command bits [2:0], a value of 0 is treated as 1, and values above 4 are treated as 4. Byte 0 (bits [7:0]) is sent first, and each byte is sent MSB first.
- R4: After the transmit bytes, the transfer receives M bytes, where M is command bits [6:4] and values above 3 are treated as 3. The receive word (offset 0x10) then holds the first received byte in bits [7:0], the next in [15:8] and the third in [23:16]. All unused upper bits read zero.
- R5: A start written with bit 7 while software mode is clear causes no SPI activity and does not set the done flag.
- R6: Writing the command register with bit 10 set sends opcode 0x05 and receives one byte, which appears in status bits [7:0]. This works in any mode and takes priority over bits 11 and 7.
- R7: Writing the command register with bit 11 set (and bit 10 clear) sends only opcode 0x06 and receives nothing. It works in any mode and leaves the receive word unchanged.
- R8: Command bits [13:12] choose which chip select is driven low: bank b drives `cs_n[b]` low. Exactly that line stays low, without a break, from the first transmitted bit to the last received bit.
- R9: Status bit 8 (offset 0x08) is set when a transfer completes. Writing the status register with bit 8 at 0 clears it. Writing it with bit 8 at 1 leaves it unchanged.
- R10: Any start request written while a transfer is in progress is ignored. The running transfer keeps its bank and length.
- R11: The mode register reads back only bits 28 and 29. The command register reads back only bits [13:12], [6:4] and [2:0]; its trigger bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| sclk | output | 1 | SPI clock, idles high |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| cs_n | output | 4 | Active-low chip selects, one per bank |

## Verification
The hardest case to reach is a second command-register write, with a different bank and trigger bits, that lands in the middle of a running transaction. The bench starts a long transfer, waits a few cycles while the chip select is low, and then issues the conflicting write. It then confirms that only one chip-select pulse occurred, on the original bank, and that the bit count was unchanged. A slave model on the bench drives random bits onto `miso` on falling clock edges. Random transmit and receive lengths, data and banks are mixed with the clamped-length corners and the opcode shortcuts, and the bench checks byte packing in both directions.

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_n
);

  logic        sw_mode, wb_mode;
  logic [2:0]  cfg_tx, cfg_rx;
  logic [1:0]  cfg_bank;
  logic        done;
  logic [7:0]  fstat;
  logic [31:0] txd;
  logic [23:0] rxd;

  logic        busy, ph;
  logic [31:0] shreg;
  logic [23:0] rxs;
  logic [5:0]  bitcnt, nbits, txbits;
  logic [1:0]  rxn, cur_bank;
  logic        cur_rsr, cur_send;

  logic        wr_c2, wr_st, req_rsr, req_we, req_send, launch, last_bit;
  logic [2:0]  tx_n, rx_n;
  logic [23:0] rx_pack;

  assign wr_c2    = bus_wr && bus_addr == 5'h04;
  assign wr_st    = bus_wr && bus_addr == 5'h08;
  assign req_rsr  = wr_c2 && bus_wdata[10];
  assign req_we   = wr_c2 && bus_wdata[11];
  assign req_send = wr_c2 && bus_wdata[7] && sw_mode;
  assign launch   = !busy && (req_rsr || req_we || req_send);
  assign last_bit = busy && ph && (bitcnt == nbits - 6'd1);

  assign tx_n = (bus_wdata[2:0] == 3'd0) ? 3'd1 :
                (bus_wdata[2:0] > 3'd4)  ? 3'd4 : bus_wdata[2:0];
  assign rx_n = (bus_wdata[6:4] > 3'd3)  ? 3'd3 : bus_wdata[6:4];

  always_comb begin
    case (rxn)
      2'd1:    rx_pack = {16'h0, rxs[7:0]};
      2'd2:    rx_pack = {8'h0, rxs[7:0], rxs[15:8]};
      2'd3:    rx_pack = {rxs[7:0], rxs[15:8], rxs[23:16]};
      default: rx_pack = 24'h0;
    endcase
  end

  assign sclk = !(busy && !ph);
  assign mosi = shreg[31];
  assign cs_n = busy ? ~(4'b0001 << cur_bank) : 4'hF;

  always_comb begin
    case (bus_addr)
      5'h00:   bus_rdata = {2'b00, wb_mode, sw_mode, 28'h0};
      5'h04:   bus_rdata = {18'h0, cfg_bank, 5'h0, cfg_rx, 1'b0, cfg_tx};
      5'h08:   bus_rdata = {23'h0, done, fstat};
      5'h0C:   bus_rdata = txd;
      5'h10:   bus_rdata = {8'h0, rxd};
      default: bus_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_mode <= 1'b0; wb_mode <= 1'b0;
      cfg_tx <= '0; cfg_rx <= '0; cfg_bank <= '0;
      txd <= '0;
    end else if (bus_wr) begin
      if (bus_addr == 5'h00) begin
        sw_mode <= bus_wdata[28];
        wb_mode <= bus_wdata[29];
      end
      if (bus_addr == 5'h04) begin
        cfg_tx   <= bus_wdata[2:0];
        cfg_rx   <= bus_wdata[6:4];
        cfg_bank <= bus_wdata[13:12];
      end
      if (bus_addr == 5'h0C) txd <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ph <= 1'b0; shreg <= '0; rxs <= '0;
      bitcnt <= '0; nbits <= '0; txbits <= '0; rxn <= '0;
      cur_bank <= '0; cur_rsr <= 1'b0; cur_send <= 1'b0;
      done <= 1'b0; fstat <= '0; rxd <= '0;
    end else begin
      if (wr_st && !bus_wdata[8]) done <= 1'b0;
      if (launch) begin
        busy     <= 1'b1;
        ph       <= 1'b0;
        bitcnt   <= '0;
        rxs      <= '0;
        cur_bank <= bus_wdata[13:12];
        cur_rsr  <= req_rsr;
        cur_send <= !req_rsr && !req_we;
        if (req_rsr) begin
          shreg <= {8'h05, 24'h0}; txbits <= 6'd8; nbits <= 6'd16; rxn <= 2'd1;
        end else if (req_we) begin
          shreg <= {8'h06, 24'h0}; txbits <= 6'd8; nbits <= 6'd8;  rxn <= 2'd0;
        end else begin
          shreg  <= {txd[7:0], txd[15:8], txd[23:16], txd[31:24]};
          txbits <= {tx_n, 3'b000};
          nbits  <= {tx_n, 3'b000} + {rx_n, 3'b000};
          rxn    <= rx_n[1:0];
        end
      end else if (busy) begin
        ph <= !ph;
        if (!ph) begin
          if (bitcnt >= txbits) rxs <= {rxs[22:0], miso};
        end else begin
          shreg  <= {shreg[30:0], 1'b0};
          bitcnt <= bitcnt + 6'd1;
          if (last_bit) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (cur_rsr)  fstat <= rxs[7:0];
            if (cur_send) rxd   <= rx_pack;
          end
        end
      end
    end
  end

  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R2
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> sclk);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(bus_wr && bus_addr == 5'h08 && !bus_wdata[8]));

  // R9
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ((&cs_n) && !$past(&cs_n)));

  // R10
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && !$past(&cs_n)) |-> $stable(cs_n));

endmodule

// File: tb/test_spi_mem_ctrl.sv
module test_spi_mem_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, miso = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sclk, mosi;
  logic [3:0]  cs_n;

  spi_mem_ctrl i_spi_mem_ctrl (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int mcnt = 0, csrises = 0, viol = 0;
  logic [63:0] mlog = '0, sbits = '0;
  logic [3:0]  csacc = '0, prev_cs = 4'hF;
  logic        prev_sclk = 1'b1, prev_mosi = 1'b0;

  always @(posedge sclk) if (!(&cs_n)) begin mlog = {mlog[62:0], mosi}; mcnt++; end
  always @(negedge sclk) miso = sbits[63 - mcnt];

  always @(negedge clk) begin
    cycles++;
    csacc |= ~cs_n;
    if ((&cs_n) && !(&prev_cs)) csrises++;
    if (!(&cs_n) && !(&prev_cs) && sclk && prev_sclk && mosi != prev_mosi) viol++;
    prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi;
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); bus_wr = 1'b0; bus_addr = a; #1 v = bus_rdata;
  endtask

  function automatic logic [63:0] txstream(input logic [31:0] d, input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v = (v << 8) | 64'(d[8*i +: 8]);
    return v;
  endfunction

  function automatic logic [31:0] exp_rx(input int ntx, input int nrx);
    logic [31:0] v = '0;
    for (int k = 0; k < nrx; k++) v |= 32'((sbits >> (64 - 8*(ntx+k+1))) & 64'hFF) << (8*k);
    return v;
  endfunction

  task automatic wait_done(output logic ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      rd(5'h08, s);
      if (s[8]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run(input logic [31:0] c2, input logic [31:0] tx, input int ntx,
                     input int nrx, input int bank, input string rq);
    logic ok;
    mcnt = 0; mlog = '0; viol = 0;
    sbits = {$urandom(), $urandom()};
    @(negedge clk); csacc = '0; csrises = 0;
    wr(5'h04, c2);
    wait_done(ok);
    repeat (2) @(negedge clk);
    chk({rq, " done"}, 64'(ok), 64'd1);
    chk({rq, " bits"}, 64'(mcnt), 64'(8*(ntx+nrx)));
    chk({rq, " mosi"}, (mlog >> (8*nrx)) & ((64'd1 << (8*ntx)) - 1), txstream(tx, ntx));
    chk("R8 bank cs", {60'h0, csacc}, 64'(4'b0001 << bank));
    chk("R8 single cs pulse", 64'(csrises), 64'd1);
    chk("R2 mosi stable while sclk high", 64'(viol), 64'd0);
    wr(5'h08, 32'h0);
  endtask

  initial begin
    logic [31:0] v, tx;
    int ntx, nrx, bank, ftx, frx;
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 cs_n", {60'h0, cs_n}, 64'hF);
    chk("R1 sclk", 64'(sclk), 64'd1);
    for (int a = 0; a <= 16; a += 4) begin
      rd(5'(a), v); chk("R1 reg zero", 64'(v), 64'd0);
    end
    rst_n = 1'b1;
    // R11
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, v); chk("R11 mode readback", 64'(v), 64'h3000_0000);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'hFFFF_F37F & ~32'h0000_0C80); rd(5'h04, v);
    chk("R11 cmd readback", 64'(v), 64'h0000_3077);
    // R5
    @(negedge clk); csacc = '0;
    wr(5'h0C, 32'h0000_009F); wr(5'h04, 32'h0000_0081);
    repeat (40) @(negedge clk);
    chk("R5 no cs", {60'h0, csacc}, 64'h0);
    rd(5'h08, v); chk("R5 no done", 64'(v[8]), 64'd0);
    // R6 in hardware mode
    run(32'h0000_2400, 32'h05, 1, 1, 2, "R6 status read");
    rd(5'h08, v); chk("R6 status byte", 64'(v[7:0]), 64'(exp_rx(1, 1)));
    // R7
    rd(5'h10, v);
    run(32'h0000_1800, 32'h06, 1, 0, 1, "R7 write enable");
    rd(5'h10, tx); chk("R7 rx untouched", 64'(tx), 64'(v));
    // R6 priority
    run(32'h0000_3C80, 32'h05, 1, 1, 3, "R6 priority");
    // R3 erase-like
    wr(5'h00, 32'h1000_0000);
    wr(5'h0C, 32'h5634_12D8);
    run(32'h0000_0084, 32'h5634_12D8, 4, 0, 0, "R3 four bytes");
    // R4 id read
    wr(5'h0C, 32'h0000_009F);
    run(32'h0000_10B1, 32'h9F, 1, 3, 1, "R4 id read");
    rd(5'h10, v); chk("R4 rx pack", 64'(v), 64'(exp_rx(1, 3)));
    // clamps
    wr(5'h0C, 32'hA1B2_C3D4);
    run(32'h0000_2080, 32'hA1B2_C3D4, 1, 0, 2, "R3 len0 clamp");
    rd(5'h10, v); chk("R4 rx zero len", 64'(v), 64'd0);
    run(32'h0000_30E7, 32'hA1B2_C3D4, 4, 3, 3, "R3 R4 len clamp");
    rd(5'h10, v); chk("R4 rx clamp", 64'(v), 64'(exp_rx(4, 3)));
    // R9
    wr(5'h04, 32'h0000_0081); repeat (30) @(negedge clk);
    wr(5'h08, 32'h0000_0100); rd(5'h08, v); chk("R9 write one keeps", 64'(v[8]), 64'd1);
    wr(5'h08, 32'h0000_0000); rd(5'h08, v); chk("R9 write zero clears", 64'(v[8]), 64'd0);
    // R10 start while busy
    begin
      logic ok;
      mcnt = 0; sbits = {$urandom(), $urandom()};
      @(negedge clk); csacc = '0; csrises = 0;
      wr(5'h04, 32'h0000_0034);
      wr(5'h04, 32'h0000_0084);
      repeat (4) @(negedge clk);
      wr(5'h04, 32'h0000_3C81);
      wait_done(ok);
      repeat (60) @(negedge clk);
      chk("R10 one pulse", 64'(csrises), 64'd1);
      chk("R10 bank kept", {60'h0, csacc}, 64'h1);
      chk("R10 length kept", 64'(mcnt), 64'd32);
      wr(5'h08, 32'h0);
    end
    // random
    for (int it = 0; it < 30; it++) begin
      ftx = $urandom_range(0, 7); frx = $urandom_range(0, 7); bank = $urandom_range(0, 3);
      ntx = (ftx == 0) ? 1 : (ftx > 4 ? 4 : ftx);
      nrx = (frx > 3) ? 3 : frx;
      tx = $urandom();
      wr(5'h0C, tx);
      run(32'(bank << 12) | 32'h80 | 32'(frx << 4) | 32'(ftx), tx, ntx, nrx, bank, "R3 random");
      rd(5'h10, v); chk("R4 random rx", 64'(v), 64'(exp_rx(ntx, nrx)));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule